// File: doc/BRIEF.md
# Palette-Index Drawing Engine

This block is a small command processor that paints into a framebuffer of 4-bit palette indices, 320 by 240 points by default. Software first loads up to four 16-bit argument words. It then writes a control byte that carries a drawing color in its upper nibble and a command code in its lower nibble. That write starts the command. The engine performs a single-pixel plot, a filled rectangle, a straight line, or a copy of an 8x8 sprite from sprite memory. It produces at most one framebuffer write per clock.

When a command ends, the engine clears the command field of the control byte and raises a one-cycle completion pulse. A command that cannot run is rejected before any drawing starts. This covers an unsupported code and any argument outside the screen or sprite table. The engine then raises a separate one-cycle pulse instead of the completion pulse. Palette lookup, scanout and scrolling belong to other blocks.

Top module: `draw_engine`

## Requirements
- R1: Registers are selected by byte offset on `reg_addr`:
  - arguments A0..A3 at offsets 0, 2, 4 and 6;
  - control at offset 8, with color in bits 7:4 and command in bits 3:0;
  - transparency key at offset 9, in bits 3:0.
  All of them read back on `reg_rdata`, other offsets read 0, and everything resets to 0.
- R2: A control write while idle starts the command it names. The command field reads that code while the engine runs. It returns to 0 when the command finishes, and `irq_done` pulses for one cycle in the cycle after the last framebuffer write.
- R3: Code 4 (pixel) writes exactly one point at (A0, A1) in the color.
- R4: Code 2 (fill) writes every point of the inclusive rectangle spanned by corners (A0, A1) and (A2, A3) exactly once, in the color. Either corner may be the smaller one.
- R5: Code 1 (line) writes exactly the integer Bresenham points from (A0, A1) to (A2, A3), both endpoints included, one write per point. The per-step rule is:
  - e2 = 2*err;
  - if e2 >= dy, then x steps;
  - if e2 <= dx, then y steps.
  The start values are dx = |A2-A0|, dy = -|A3-A1| and err = dx+dy.
- R6: Code 0 (blit) copies sprite A0 with its top-left corner at (A1, A2).
  - Sprite memory is read at address A0*64 + row*8 + col, with one cycle of read latency.
  - The point written is (A1+col, A2+row), and its value is the sprite pixel.
  - Points that land off screen are dropped.
- R7: During a blit, a sprite pixel equal to the transparency key is not written.
- R8: Some control writes are rejected:
  - codes 3 and 5..15;
  - a pixel, fill or line argument with X >= width or Y >= height;
  - a blit with sprite index >= sprite count, or an origin off screen.
  A rejected write gives a one-cycle `irq_invalid` pulse, no framebuffer writes, and a command field that reads 0.
- R9: Writes to any register while a command runs have no effect on its readback or on the drawing.
- R10: `irq_done` and `irq_invalid` never rise together, and every framebuffer write lies on screen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational readback of the addressed register |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_x | output | clog2(SCR_W) | Write column |
| fb_y | output | clog2(SCR_H) | Write row |
| fb_pix | output | 4 | Palette index written |
| spr_addr | output | clog2(SPR_COUNT)+6 | Sprite memory pixel address |
| spr_data | input | 4 | Sprite pixel, one cycle after its address |
| irq_done | output | 1 | Command-finished pulse |
| irq_invalid | output | 1 | Rejected-command pulse |

## Verification
The bench builds the engine with a 16x12 screen and a 4-entry sprite table. At that size a single run can cover:
- a pixel at every point of the screen;
- lines from three anchor points to every point;
- fills over all corner orderings of a grid of edges;
- every sprite blitted at each column on top, middle and bottom rows, which drives clipping on both edges.

Each command's framebuffer image and write count are compared with a model computed in the bench. Rejection is probed one past each limit.

// File: rtl/draw_engine.sv
module draw_engine #(
  parameter int SCR_W     = 320,
  parameter int SCR_H     = 240,
  parameter int SPR_COUNT = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_we,
  input  logic [3:0]                     reg_addr,
  input  logic [15:0]                    reg_wdata,
  output logic [15:0]                    reg_rdata,
  output logic                           fb_we,
  output logic [$clog2(SCR_W)-1:0]       fb_x,
  output logic [$clog2(SCR_H)-1:0]       fb_y,
  output logic [3:0]                     fb_pix,
  output logic [$clog2(SPR_COUNT)+5:0]   spr_addr,
  input  logic [3:0]                     spr_data,
  output logic                           irq_done,
  output logic                           irq_invalid
);
  localparam int XW = $clog2(SCR_W);
  localparam int YW = $clog2(SCR_H);
  localparam int SW = $clog2(SPR_COUNT);
  localparam logic [15:0] W16 = 16'(SCR_W);
  localparam logic [15:0] H16 = 16'(SCR_H);
  localparam logic [15:0] S16 = 16'(SPR_COUNT);
  localparam logic signed [17:0] W18 = 18'(SCR_W);
  localparam logic signed [17:0] H18 = 18'(SCR_H);

  typedef enum logic [2:0] {S_IDLE, S_PIX, S_FILL, S_LINE, S_BLIT, S_BTAIL} st_t;
  st_t st;

  logic [15:0] arg [4];
  logic [3:0]  color, cmd, tmask;
  logic signed [17:0] cx, cy, ex, ey, xs, dx, dy, err;
  logic        sx_neg, sy_neg;
  logic [SW-1:0] sidx;
  logic [5:0]  k;
  logic [15:0] bx, by, bl_x, bl_y;
  logic        bl_v;

  wire idle = (st == S_IDLE);
  wire [3:0] ncmd = reg_wdata[3:0];
  wire signed [17:0] ax0 = {2'b00, arg[0]};
  wire signed [17:0] ay0 = {2'b00, arg[1]};
  wire signed [17:0] ax1 = {2'b00, arg[2]};
  wire signed [17:0] ay1 = {2'b00, arg[3]};

  logic start_ok;
  always_comb begin
    case (ncmd)
      4'd0:       start_ok = arg[0] < S16 && arg[1] < W16 && arg[2] < H16;
      4'd1, 4'd2: start_ok = arg[0] < W16 && arg[1] < H16 && arg[2] < W16 && arg[3] < H16;
      4'd4:       start_ok = arg[0] < W16 && arg[1] < H16;
      default:    start_ok = 1'b0;
    endcase
  end

  wire signed [17:0] e2     = err <<< 1;
  wire               step_x = e2 >= dy;
  wire               step_y = e2 <= dx;
  wire               at_end = (cx == ex) && (cy == ey);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < 4; i++) arg[i] <= '0;
      color <= '0; cmd <= '0; tmask <= '0;
      cx <= '0; cy <= '0; ex <= '0; ey <= '0; xs <= '0;
      dx <= '0; dy <= '0; err <= '0; sx_neg <= 1'b0; sy_neg <= 1'b0;
      sidx <= '0; k <= '0; bx <= '0; by <= '0;
      bl_x <= '0; bl_y <= '0; bl_v <= 1'b0;
      irq_done <= 1'b0; irq_invalid <= 1'b0;
    end else begin
      irq_done    <= 1'b0;
      irq_invalid <= 1'b0;
      bl_v        <= 1'b0;
      if (reg_we && idle) begin
        case (reg_addr)
          4'd0, 4'd2, 4'd4, 4'd6: arg[reg_addr[2:1]] <= reg_wdata;
          4'd9: tmask <= reg_wdata[3:0];
          4'd8: begin
            color <= reg_wdata[7:4];
            if (!start_ok) irq_invalid <= 1'b1;
            else begin
              cmd <= ncmd;
              case (ncmd)
                4'd4: begin cx <= ax0; cy <= ay0; st <= S_PIX; end
                4'd2: begin
                  xs <= (ax0 < ax1) ? ax0 : ax1;
                  cx <= (ax0 < ax1) ? ax0 : ax1;
                  ex <= (ax0 < ax1) ? ax1 : ax0;
                  cy <= (ay0 < ay1) ? ay0 : ay1;
                  ey <= (ay0 < ay1) ? ay1 : ay0;
                  st <= S_FILL;
                end
                4'd1: begin
                  cx <= ax0; cy <= ay0; ex <= ax1; ey <= ay1;
                  sx_neg <= ax1 < ax0;
                  sy_neg <= ay1 < ay0;
                  dx  <= (ax1 < ax0) ? ax0 - ax1 : ax1 - ax0;
                  dy  <= (ay1 < ay0) ? ay1 - ay0 : ay0 - ay1;
                  err <= ((ax1 < ax0) ? ax0 - ax1 : ax1 - ax0)
                       + ((ay1 < ay0) ? ay1 - ay0 : ay0 - ay1);
                  st <= S_LINE;
                end
                default: begin
                  sidx <= arg[0][SW-1:0];
                  bx <= arg[1]; by <= arg[2]; k <= '0;
                  st <= S_BLIT;
                end
              endcase
            end
          end
          default: ;
        endcase
      end
      case (st)
        S_PIX: begin st <= S_IDLE; cmd <= '0; irq_done <= 1'b1; end
        S_FILL: begin
          if (cx != ex) cx <= cx + 18'sd1;
          else if (cy != ey) begin cx <= xs; cy <= cy + 18'sd1; end
          else begin st <= S_IDLE; cmd <= '0; irq_done <= 1'b1; end
        end
        S_LINE: begin
          if (at_end) begin st <= S_IDLE; cmd <= '0; irq_done <= 1'b1; end
          else begin
            err <= err + (step_x ? dy : 18'sd0) + (step_y ? dx : 18'sd0);
            if (step_x) cx <= sx_neg ? cx - 18'sd1 : cx + 18'sd1;
            if (step_y) cy <= sy_neg ? cy - 18'sd1 : cy + 18'sd1;
          end
        end
        S_BLIT: begin
          bl_v <= 1'b1;
          bl_x <= bx + {13'd0, k[2:0]};
          bl_y <= by + {13'd0, k[5:3]};
          k    <= k + 6'd1;
          if (k == 6'd63) st <= S_BTAIL;
        end
        S_BTAIL: begin st <= S_IDLE; cmd <= '0; irq_done <= 1'b1; end
        default: ;
      endcase
    end
  end

  assign spr_addr = {sidx, k};

  wire drawing = (st == S_PIX) || (st == S_FILL) || (st == S_LINE);
  wire bl_hit  = bl_v && (spr_data != tmask) && (bl_x < W16) && (bl_y < H16);

  assign fb_we  = drawing || bl_hit;
  assign fb_x   = drawing ? cx[XW-1:0] : bl_x[XW-1:0];
  assign fb_y   = drawing ? cy[YW-1:0] : bl_y[YW-1:0];
  assign fb_pix = drawing ? color : spr_data;

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = arg[0];
      4'd2:    reg_rdata = arg[1];
      4'd4:    reg_rdata = arg[2];
      4'd6:    reg_rdata = arg[3];
      4'd8:    reg_rdata = {8'd0, color, cmd};
      4'd9:    reg_rdata = {12'd0, tmask};
      default: reg_rdata = '0;
    endcase
  end

  a_r10_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_invalid));
  a_r10_draw_onscreen: assert property (@(posedge clk) disable iff (!rst_n)
    drawing |-> (cx >= 18'sd0 && cx < W18 && cy >= 18'sd0 && cy < H18));
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_invalid |-> (idle && !fb_we && cmd == 4'd0));
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (idle && cmd == 4'd0));
  a_r9_busy_color_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd8 && !idle) |=> $stable(color));
  a_r9_busy_key_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd9 && !idle) |=> $stable(tmask));
  a_r2_busy_shows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && st != S_BLIT && st != S_BTAIL) |-> cmd != 4'd0);
endmodule

// File: tb/tb_draw_engine.sv
module tb_draw_engine;
  localparam int W = 16;
  localparam int H = 12;
  localparam int SC = 4;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam int AW = $clog2(SC) + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic fb_we;
  logic [XW-1:0] fb_x;
  logic [YW-1:0] fb_y;
  logic [3:0] fb_pix;
  logic [AW-1:0] spr_addr;
  logic [3:0] spr_data = '0;
  logic irq_done, irq_invalid;

  always #2.5 clk = ~clk;

  draw_engine #(.SCR_W(W), .SCR_H(H), .SPR_COUNT(SC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fb_we(fb_we), .fb_x(fb_x),
    .fb_y(fb_y), .fb_pix(fb_pix), .spr_addr(spr_addr), .spr_data(spr_data),
    .irq_done(irq_done), .irq_invalid(irq_invalid));

  function automatic logic [3:0] spix(int a);
    int v;
    v = a * 5 + a / 7 + 3;
    return v[3:0];
  endfunction

  always @(posedge clk) spr_data <= spix(int'(spr_addr));

  int nchk = 0, nerr = 0;
  int fbm [W*H];
  int expf [W*H];
  int nwr = 0, nexp = 0;
  bit done_seen, inv_seen;

  always @(negedge clk) begin
    if (fb_we) begin
      fbm[int'(fb_y) * W + int'(fb_x)] = int'(fb_pix);
      nwr++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < W*H; i++) begin fbm[i] = -1; expf[i] = -1; end
    nwr = 0; nexp = 0;
  endtask

  task automatic setx(int x, int y, int v);
    if (x < W && y < H) begin expf[y*W + x] = v; nexp++; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(input logic [3:0] col, input logic [3:0] code);
    done_seen = 1'b0; inv_seen = 1'b0;
    wr(4'd8, {8'd0, col, code});
    for (int i = 0; i < 2000; i++) begin
      if (irq_done) begin done_seen = 1'b1; break; end
      if (irq_invalid) begin inv_seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic compare(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < W*H; i++) if (fbm[i] != expf[i]) mism++;
    chk(done_seen, req, int'(done_seen), 1);
    chk(mism == 0, req, mism, 0);
    chk(nwr == nexp, req, nwr, nexp);
  endtask

  task automatic set_args(int a0, int a1, int a2, int a3);
    wr(4'd0, 16'(a0)); wr(4'd2, 16'(a1)); wr(4'd4, 16'(a2)); wr(4'd6, 16'(a3));
  endtask

  task automatic exp_line(int x0, int y0, int x1, int y1, int col);
    int dx, dy, sx, sy, err, e2;
    dx = (x1 > x0) ? x1 - x0 : x0 - x1;
    dy = (y1 > y0) ? y0 - y1 : y1 - y0;
    sx = (x1 < x0) ? -1 : 1;
    sy = (y1 < y0) ? -1 : 1;
    err = dx + dy;
    forever begin
      setx(x0, y0, col);
      if (x0 == x1 && y0 == y1) break;
      e2 = 2 * err;
      if (e2 >= dy) begin err += dy; x0 += sx; end
      if (e2 <= dx) begin err += dx; y0 += sy; end
    end
  endtask

  task automatic reject(input string req, input logic [3:0] code);
    logic [15:0] d;
    clear();
    run(4'h9, code);
    chk(inv_seen, req, int'(inv_seen), 1);
    repeat (3) @(negedge clk);
    chk(nwr == 0, req, nwr, 0);
    rd(4'd8, d);
    chk(d[3:0] == 4'd0, req, int'(d[3:0]), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int xs[4], ys[4];
    xs = '{0, 5, 15, 3};
    ys = '{0, 11, 4, 7};
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk(d == 16'd0, "R1 reset readback", int'(d), 0);
    end
    chk(!fb_we && !irq_done && !irq_invalid, "R1 reset outputs",
        int'({fb_we, irq_done, irq_invalid}), 0);
    // R1 register map
    set_args(16'h1234, 16'h00ab, 16'hfff0, 16'h0007);
    wr(4'd9, 16'h000c);
    rd(4'd0, d); chk(d == 16'h1234, "R1 map A0", int'(d), 'h1234);
    rd(4'd2, d); chk(d == 16'h00ab, "R1 map A1", int'(d), 'h00ab);
    rd(4'd4, d); chk(d == 16'hfff0, "R1 map A2", int'(d), 'hfff0);
    rd(4'd6, d); chk(d == 16'h0007, "R1 map A3", int'(d), 'h0007);
    rd(4'd9, d); chk(d == 16'h000c, "R1 map key", int'(d), 'hc);
    rd(4'd1, d); chk(d == 16'h0000, "R1 map hole", int'(d), 0);

    // R2 R3 pixel timing
    clear();
    set_args(3, 4, 0, 0);
    wr(4'd8, 16'h0054);
    chk(fb_we && fb_x == 4'd3 && fb_y == 4'd4 && fb_pix == 4'd5, "R3 pixel write",
        int'({fb_we, fb_x, fb_y, fb_pix}), int'({1'b1, 4'd3, 4'd4, 4'd5}));
    rd(4'd8, d); chk(d == 16'h0054, "R2 cmd shown while busy", int'(d), 'h54);
    @(negedge clk);
    chk(irq_done && !fb_we, "R2 done pulse", int'({irq_done, fb_we}), 2);
    rd(4'd8, d); chk(d == 16'h0050, "R2 cmd cleared", int'(d), 'h50);
    @(negedge clk);
    chk(!irq_done, "R2 done one cycle", int'(irq_done), 0);

    // R3 pixel sweep
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        clear();
        set_args(x, y, 0, 0);
        setx(x, y, (x + y) & 15);
        run(4'((x + y) & 15), 4'd4);
        compare("R3 pixel");
      end

    // R4 fill
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int e = 0; e < 4; e++) begin
            int xl, xh, yl, yh;
            clear();
            xl = (xs[a] < xs[c]) ? xs[a] : xs[c]; xh = xs[a] + xs[c] - xl;
            yl = (ys[b] < ys[e]) ? ys[b] : ys[e]; yh = ys[b] + ys[e] - yl;
            for (int y = yl; y <= yh; y++)
              for (int x = xl; x <= xh; x++) setx(x, y, a + c);
            set_args(xs[a], ys[b], xs[c], ys[e]);
            run(4'(a + c), 4'd2);
            compare("R4 fill");
          end

    // R5 line
    for (int s = 0; s < 3; s++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          int x0, y0;
          x0 = (s == 0) ? 0 : (s == 1) ? W - 1 : 7;
          y0 = (s == 0) ? 0 : (s == 1) ? H - 1 : 5;
          clear();
          exp_line(x0, y0, x, y, s + 1);
          set_args(x0, y0, x, y);
          run(4'(s + 1), 4'd1);
          compare("R5 line");
        end

    // R6 R7 blit
    for (int i = 0; i < SC; i++)
      for (int yi = 0; yi < 3; yi++)
        for (int x = 0; x < W; x++) begin
          int y, key;
          y = (yi == 0) ? 0 : (yi == 1) ? 6 : H - 1;
          key = int'(spix(i * 64 + x));
          clear();
          for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
              int p;
              p = int'(spix(i * 64 + r * 8 + c));
              if (p != key) setx(x + c, y + r, p);
            end
          set_args(i, x, y, 0);
          wr(4'd9, 16'(key));
          run(4'h0, 4'd0);
          compare("R6 R7 blit");
        end

    // R9 writes while busy
    clear();
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) setx(x, y, 6);
    set_args(0, 0, W - 1, H - 1);
    wr(4'd9, 16'd2);
    wr(4'd8, 16'h0062);
    wr(4'd8, 16'h00f4);
    wr(4'd0, 16'd9);
    wr(4'd9, 16'd7);
    rd(4'd8, d); chk(d == 16'h0062, "R9 control held", int'(d), 'h62);
    done_seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (irq_done) begin done_seen = 1'b1; break; end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    compare("R9 busy ignored");
    rd(4'd0, d); chk(d == 16'd0, "R9 arg held", int'(d), 0);
    rd(4'd9, d); chk(d == 16'd2, "R9 key held", int'(d), 2);

    // R8 rejections
    set_args(W, 0, 0, 0);           reject("R8 pixel x", 4'd4);
    set_args(0, H, 0, 0);           reject("R8 pixel y", 4'd4);
    set_args(0, 0, W, 0);           reject("R8 fill x2", 4'd2);
    set_args(0, 0, 1, H);           reject("R8 line y2", 4'd1);
    set_args(SC, 0, 0, 0);          reject("R8 blit index", 4'd0);
    set_args(0, W, 0, 0);           reject("R8 blit x", 4'd0);
    set_args(0, 0, H, 0);           reject("R8 blit y", 4'd0);
    set_args(1, 1, 1, 1);
    reject("R8 code 3", 4'd3);
    reject("R8 code 5", 4'd5);
    reject("R8 code 15", 4'd15);
    chk(!irq_done, "R10 no done on reject", int'(irq_done), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule